// File: doc/BRIEF.md
# ADC Channel Pulse Processor

This block takes one 12-bit converter sample per clock and turns pulses in that stream into event records. Each sample first passes through a delay line whose length software selects (0 to 255 samples). The delayed stream is compared against a threshold to form a self trigger, and a separate external trigger pin can start an event as well. When either one fires while the channel is idle, a record is captured around the trigger point. The record holds a selectable number of samples from before the trigger, the trigger sample itself, and a selectable number of samples after it.

After capture the channel walks the record once to find its largest sample and the sum of all its samples. It also holds the value of a free-running cycle counter taken when the trigger was registered. It then raises a done flag. While done is high, the raw samples can be read by address from the 256-entry record buffer. A one-cycle acknowledge releases the channel to wait for the next pulse. Triggers that arrive while an event is being captured, summed or held are dropped.

Top module: `adc_pulse_channel`

## Requirements
- R1: After reset, `evt_done` is 0 and `evt_peak`, `evt_sum`, `evt_ts` and `evt_len` are all 0.
- R2: The delayed stream used for triggering and capture lags the input by `dly_sel` samples (0 to 255). A sample driven on `smp_in` and taken at clock edge k can fire the self trigger, which is then registered at edge k+`dly_sel`+1.
- R3: The self trigger fires only on a rising crossing: the current delayed sample is >= `thr` and the previous one was < `thr`. A stream that stays at or above `thr` never fires again until it has dropped below `thr`.
- R4: The external trigger is registered without delay. `ext_trig` taken at edge k registers the trigger at edge k+1. The trigger sample is then the delayed sample present at that time, which is the input sample taken at edge k-`dly_sel`.
- R5: A record holds `pre_len` samples before the trigger sample (0 to 31), the trigger sample, and `post_len` samples after it. Its length `evt_len` is `pre_len`+1+`post_len`. If that exceeds 256, the number of following samples is cut so that `evt_len` is exactly 256.
- R6: `evt_peak` is the largest sample of the record. `evt_sum` is the unsigned sum of all record samples in 20 bits, which holds 256 samples of 4095 (1048320) without overflow.
- R7: `evt_ts` is the value of a 32-bit cycle counter at the clock edge that registers the trigger. The counter is 0 at the first edge with reset low and rises by 1 each clock.
- R8: While `evt_done` is high, `rd_data` gives record sample `rd_addr` one clock after `rd_addr` is applied. Address 0 is the oldest pre-trigger sample and address `evt_len`-1 is the newest.
- R9: Triggers during capture, summation or the done state are ignored, so one pulse with ripple across the threshold yields one event.
- R10: `evt_done` stays high until `rd_ack` is sampled high. It is low on the following clock and the channel is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| smp_in | input | 12 | Converter sample |
| ext_trig | input | 1 | External trigger request |
| thr | input | 12 | Self-trigger threshold |
| dly_sel | input | 8 | Delay line length in samples |
| pre_len | input | 5 | Samples kept before the trigger sample |
| post_len | input | 8 | Samples kept after the trigger sample |
| rd_addr | input | 8 | Record sample index for readout |
| rd_ack | input | 1 | Releases the held event |
| rd_data | output | 12 | Record sample at the previous `rd_addr` |
| evt_done | output | 1 | Event record ready |
| evt_peak | output | 12 | Largest record sample |
| evt_sum | output | 20 | Sum of record samples |
| evt_ts | output | 32 | Cycle count at trigger |
| evt_len | output | 9 | Number of record samples |

## Verification
Every cycle, the assertions check the hand-off rules of the done flag. These are: done holding until acknowledged, dropping right after the acknowledge, and never returning on the next cycle. They also check that the time stamp stays fixed while an event is held, that the record length stays within 1 to 256, and that the sum is consistent with the peak and the length. The exact latency through the delay line, the rising-crossing rule, the placement of the pre-trigger window, the raw buffer contents and the dropping of ripple triggers depend on the sample history. Only the bench scenarios show these: pulses are driven, the expected records are predicted from the driven samples, and the results are compared.

// File: rtl/apc_pkg.sv
package apc_pkg;
    localparam int SMP_W  = 12;
    localparam int DLY_AW = 8;
    localparam int PRE_W  = 5;
    localparam int POST_W = 8;
    localparam int BUF_AW = 8;
    localparam int LEN_W  = BUF_AW + 1;
    localparam int SUM_W  = 20;
    localparam int TS_W   = 32;
    localparam int BUF_DEPTH = 1 << BUF_AW;

    typedef logic [SMP_W-1:0] smp_t;

    typedef enum logic [1:0] {
        REC_IDLE = 2'd0,
        REC_CAPT = 2'd1,
        REC_SCAN = 2'd2,
        REC_DONE = 2'd3
    } rec_state_e;

    typedef struct packed {
        smp_t             peak;
        logic [SUM_W-1:0] sum;
        logic [TS_W-1:0]  ts;
        logic [LEN_W-1:0] len;
    } evt_rec_t;

    // Number of following samples that still fits the record buffer.
    function automatic logic [LEN_W-1:0] fit_post(input logic [PRE_W-1:0] pre,
                                                  input logic [POST_W-1:0] post);
        logic [LEN_W-1:0] p, q;
        p = LEN_W'(pre);
        q = LEN_W'(post);
        if (p + q > LEN_W'(BUF_DEPTH - 1))
            return LEN_W'(BUF_DEPTH - 1) - p;
        return q;
    endfunction
endpackage

// File: rtl/apc_delay.sv
module apc_delay #(
    parameter int DW = apc_pkg::SMP_W,
    parameter int AW = apc_pkg::DLY_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] din,
    input  logic [AW-1:0] dsel,
    output logic [DW-1:0] dout
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] ring [DEPTH];
    logic [AW-1:0] wp;

    always_ff @(posedge clk) begin
        ring[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp   <= '0;
            dout <= '0;
        end else begin
            wp   <= wp + 1'b1;
            dout <= (dsel == '0) ? din : ring[wp - dsel];
        end
    end
endmodule

// File: rtl/apc_trigger.sv
module apc_trigger #(
    parameter int DW = apc_pkg::SMP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] smp,
    input  logic [DW-1:0] thr,
    input  logic          ext_in,
    output logic          fire
);
    logic armed;   // previous delayed sample was below threshold
    logic ext_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            ext_q <= 1'b0;
        end else begin
            armed <= (smp < thr);
            ext_q <= ext_in;
        end
    end

    assign fire = (armed && (smp >= thr)) || ext_q;
endmodule

// File: rtl/apc_recorder.sv
module apc_recorder
    import apc_pkg::*;
#(
    parameter int AW = BUF_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  smp_t              smp,
    input  logic              trig,
    input  logic [PRE_W-1:0]  pre_len,
    input  logic [POST_W-1:0] post_len,
    input  logic [TS_W-1:0]   tnow,
    input  logic [AW-1:0]     rd_addr,
    input  logic              rd_ack,
    output smp_t              rd_data,
    output logic              done,
    output evt_rec_t          rec
);
    localparam int DEPTH = 1 << AW;

    smp_t             mem [DEPTH];
    rec_state_e       st;
    logic [AW-1:0]    wp, start, remain;
    logic [LEN_W-1:0] idx, post_fit;
    logic             wr_en;
    smp_t             scan_v;

    assign post_fit = fit_post(pre_len, post_len);
    assign wr_en    = (st == REC_IDLE) || (st == REC_CAPT);
    assign scan_v   = mem[start + idx[AW-1:0]];
    assign done     = (st == REC_DONE);

    // Buffer runs as a ring while idle, which keeps the pre-trigger history.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= smp;
        rd_data <= mem[start + rd_addr];
    end

    always_ff @(posedge clk) begin
        if (rst) wp <= '0;
        else if (wr_en) wp <= wp + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= REC_IDLE;
            start  <= '0;
            remain <= '0;
            idx    <= '0;
            rec    <= '0;
        end else begin
            case (st)
                REC_IDLE: if (trig) begin
                    start    <= wp - AW'(pre_len);
                    remain   <= post_fit[AW-1:0];
                    rec.len  <= LEN_W'(pre_len) + post_fit + 1'b1;
                    rec.ts   <= tnow;
                    rec.peak <= '0;
                    rec.sum  <= '0;
                    idx      <= '0;
                    st       <= (post_fit == '0) ? REC_SCAN : REC_CAPT;
                end
                REC_CAPT: begin
                    remain <= remain - 1'b1;
                    if (remain == AW'(1)) st <= REC_SCAN;
                end
                REC_SCAN: begin
                    if (scan_v > rec.peak) rec.peak <= scan_v;
                    rec.sum <= rec.sum + SUM_W'(scan_v);
                    idx     <= idx + 1'b1;
                    if (idx == rec.len - 1'b1) st <= REC_DONE;
                end
                REC_DONE: if (rd_ack) st <= REC_IDLE;
                default:  st <= REC_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_pulse_channel.sv
module adc_pulse_channel
    import apc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SMP_W-1:0]  smp_in,
    input  logic              ext_trig,
    input  logic [SMP_W-1:0]  thr,
    input  logic [DLY_AW-1:0] dly_sel,
    input  logic [PRE_W-1:0]  pre_len,
    input  logic [POST_W-1:0] post_len,
    input  logic [BUF_AW-1:0] rd_addr,
    input  logic              rd_ack,
    output logic [SMP_W-1:0]  rd_data,
    output logic              evt_done,
    output logic [SMP_W-1:0]  evt_peak,
    output logic [SUM_W-1:0]  evt_sum,
    output logic [TS_W-1:0]   evt_ts,
    output logic [LEN_W-1:0]  evt_len
);
    smp_t            dly_smp;
    logic            fire;
    logic [TS_W-1:0] tcount;
    evt_rec_t        rec;

    always_ff @(posedge clk) begin
        if (rst) tcount <= '0;
        else     tcount <= tcount + 1'b1;
    end

    apc_delay #(.DW(SMP_W), .AW(DLY_AW)) u_dly (
        .clk(clk), .rst(rst), .din(smp_in), .dsel(dly_sel), .dout(dly_smp)
    );

    apc_trigger #(.DW(SMP_W)) u_trig (
        .clk(clk), .rst(rst), .smp(dly_smp), .thr(thr), .ext_in(ext_trig), .fire(fire)
    );

    apc_recorder #(.AW(BUF_AW)) u_rec (
        .clk(clk), .rst(rst), .smp(dly_smp), .trig(fire),
        .pre_len(pre_len), .post_len(post_len), .tnow(tcount),
        .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .done(evt_done), .rec(rec)
    );

    assign evt_peak = rec.peak;
    assign evt_sum  = rec.sum;
    assign evt_ts   = rec.ts;
    assign evt_len  = rec.len;
endmodule

// File: rtl/apc_checker.sv
module apc_checker
    import apc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             evt_done,
    input logic             rd_ack,
    input logic [SMP_W-1:0] evt_peak,
    input logic [SUM_W-1:0] evt_sum,
    input logic [TS_W-1:0]  evt_ts,
    input logic [LEN_W-1:0] evt_len
);
    p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (evt_done && !rd_ack) |=> evt_done);

    p_ack_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (evt_done && rd_ack) |=> !evt_done);

    p_no_back_to_back_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(evt_done) |=> !evt_done);

    p_len_range_r5: assert property (@(posedge clk) disable iff (rst)
        evt_done |-> (evt_len >= LEN_W'(1) && evt_len <= LEN_W'(BUF_DEPTH)));

    p_peak_in_sum_r6: assert property (@(posedge clk) disable iff (rst)
        evt_done |-> (evt_sum >= SUM_W'(evt_peak)));

    p_sum_bound_r6: assert property (@(posedge clk) disable iff (rst)
        evt_done |-> (32'(evt_sum) <= 32'(evt_len) * 32'd4095));

    p_ts_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (evt_done && $past(evt_done)) |-> $stable(evt_ts));
endmodule

bind adc_pulse_channel apc_checker u_chk (
    .clk(clk), .rst(rst), .evt_done(evt_done), .rd_ack(rd_ack),
    .evt_peak(evt_peak), .evt_sum(evt_sum), .evt_ts(evt_ts), .evt_len(evt_len)
);

// File: tb/adc_pulse_channel_test.sv
module adc_pulse_channel_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] smp_in, thr, rd_data, evt_peak;
    logic        ext_trig, rd_ack, evt_done;
    logic [7:0]  dly_sel, post_len, rd_addr;
    logic [4:0]  pre_len;
    logic [19:0] evt_sum;
    logic [31:0] evt_ts;
    logic [8:0]  evt_len;

    always #2 clk = ~clk;

    adc_pulse_channel uut (
        .clk(clk), .rst(rst), .smp_in(smp_in), .ext_trig(ext_trig), .thr(thr),
        .dly_sel(dly_sel), .pre_len(pre_len), .post_len(post_len),
        .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .evt_done(evt_done), .evt_peak(evt_peak), .evt_sum(evt_sum),
        .evt_ts(evt_ts), .evt_len(evt_len)
    );

    int checks = 0, fails = 0, cyc = 0, base_v = 0, pushed = 0, seen = 0;
    bit finished = 0;
    int xs[int];
    int pulse_q[$];
    int q_peak[$], q_sum[$], q_len[$], q_ts[$], q_raw[$];
    string q_tag[$];

    always @(posedge clk) if (!rst) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input int v, input bit e);
        @(negedge clk);
        smp_in   = 12'(v);
        ext_trig = e;
        xs[cyc]  = v;
    endtask

    function automatic int val_at(input int i);
        return xs.exists(i) ? xs[i] : base_v;
    endfunction

    // Driver: predicts the record from the driven samples and queues it.
    task automatic run_event(input int thr_v, input int dly_v, input int pre_v,
                             input int post_v, input int base, input int ext_off,
                             input string tag);
        int k0, ktr, ts, len, postc, pk, sm, prev;
        thr = 12'(thr_v); pre_len = 5'(pre_v); post_len = 8'(post_v);
        base_v = base;
        repeat (260) drive(base, 1'b0);
        dly_sel = 8'(dly_v);
        repeat (dly_v + 40) drive(base, 1'b0);
        k0 = cyc + 1;
        foreach (pulse_q[j]) xs[k0 + j] = pulse_q[j];
        ktr = -1; ts = 0;
        if (ext_off >= 0) begin
            ktr = k0 + ext_off - dly_v;
            ts  = k0 + ext_off + 1;
        end else begin
            foreach (pulse_q[j]) begin
                prev = (j == 0) ? base : pulse_q[j-1];
                if (ktr < 0 && pulse_q[j] >= thr_v && prev < thr_v) ktr = k0 + j;
            end
            ts = ktr + dly_v + 1;
        end
        len = pre_v + 1 + post_v;
        if (len > 256) len = 256;
        postc = len - 1 - pre_v;
        pk = 0; sm = 0;
        for (int i = ktr - pre_v; i <= ktr + postc; i++) begin
            if (val_at(i) > pk) pk = val_at(i);
            sm += val_at(i);
            q_raw.push_back(val_at(i));
        end
        q_peak.push_back(pk); q_sum.push_back(sm); q_len.push_back(len);
        q_ts.push_back(ts); q_tag.push_back(tag);
        pushed++;
        foreach (pulse_q[j]) drive(pulse_q[j], (j == ext_off));
        while (seen < pushed) drive(base, 1'b0);
        repeat (5) drive(base, 1'b0);
    endtask

    // Monitor: pops the expected record when the channel reports done.
    initial begin
        int bad, first_act, first_exp, e_len, e;
        string tg;
        forever begin
            @(negedge clk);
            if (!rst && evt_done) begin
                if (q_len.size() == 0) begin
                    chk(1'b0, "R9 unexpected extra event", 1, 0);
                end else begin
                    tg    = q_tag.pop_front();
                    e_len = q_len.pop_front();
                    e     = q_peak.pop_front();
                    chk(evt_peak == 12'(e), {tg, " R6 peak"}, evt_peak, e);
                    e     = q_sum.pop_front();
                    chk(evt_sum == 20'(e), {tg, " R6 sum"}, evt_sum, e);
                    chk(evt_len == 9'(e_len), {tg, " R5 length"}, evt_len, e_len);
                    e     = q_ts.pop_front();
                    chk(evt_ts == 32'(e), {tg, " R7 time stamp"}, evt_ts, e);
                    bad = 0; first_act = 0; first_exp = 0;
                    for (int i = 0; i < e_len; i++) begin
                        rd_addr = 8'(i);
                        @(negedge clk);
                        e = q_raw.pop_front();
                        if (int'(rd_data) != e) begin
                            if (bad == 0) begin first_act = rd_data; first_exp = e; end
                            bad++;
                        end
                    end
                    chk(bad == 0, {tg, " R8 raw sample"}, first_act, first_exp);
                    chk(evt_done == 1'b1, {tg, " R10 done held"}, evt_done, 1);
                end
                rd_ack = 1'b1;
                @(negedge clk);
                rd_ack = 1'b0;
                chk(evt_done == 1'b0, "R10 done cleared by ack", evt_done, 0);
                seen++;
            end
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1;
            chk(1'b0, "watchdog expired", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; smp_in = 12'd4095; ext_trig = 1'b0; thr = 12'd0; dly_sel = 8'd0;
        pre_len = 5'd31; post_len = 8'd255; rd_addr = 8'd0; rd_ack = 1'b0; base_v = 4095;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(evt_done == 1'b0, "R1 done after reset", evt_done, 0);
        chk(evt_peak == 12'd0 && evt_sum == 20'd0, "R1 peak/sum after reset", evt_sum, 0);
        chk(evt_ts == 32'd0 && evt_len == 9'd0, "R1 ts/len after reset", evt_len, 0);

        // Full-scale record, external start, length cut to 256; a stream held
        // above a zero threshold never crosses, so only one event may appear.
        pulse_q = {4095};
        run_event(0, 0, 31, 255, 4095, 0, "E4 R4 R5 R6 full-scale");

        // Self trigger on a rising crossing; level held above threshold after ack.
        pulse_q = {150, 300, 520, 800};
        for (int i = 0; i < 80; i++) pulse_q.push_back(640);
        pulse_q.push_back(380); pulse_q.push_back(120);
        run_event(500, 0, 4, 10, 100, -1, "E1 R3 crossing");

        // Delayed stream with ripple crossing twice inside the window.
        pulse_q = {200, 600, 900, 450, 700, 1000, 800, 300, 150};
        run_event(500, 37, 31, 20, 100, -1, "E2 R2 R9 ripple");

        // External trigger through a 5-sample delay, pulse below threshold.
        pulse_q = {400, 800, 1200, 900, 300};
        run_event(3000, 5, 2, 6, 50, 2, "E3 R4 external");

        // Longest delay, single-sample record.
        pulse_q = {2500, 10};
        run_event(2000, 255, 0, 0, 10, -1, "E5 R2 max delay");

        repeat (20) drive(base_v, 1'b0);
        chk(seen == 5 && q_len.size() == 0, "R9 event count", seen, 5);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule